// File: doc/BRIEF.md
# Stereo Soft-Ramped Volume Stage

This block scales a pair of signed 24-bit PCM samples, one left and one right, each time a frame strobe marks a new word-clock frame. Each channel has its own 8-bit volume code. The applied gain is a fixed boost of BOOST_SHIFT times 6 dB multiplied by the code's gain. The code's gain runs in half-decibel steps from full attenuation up to +24 dB, and code 0x00 silences the channel. The result is clamped to the 24-bit signed range.

A change of code is not applied at once. Each channel holds an applied code that walks one half-decibel step toward the new target every eight frames. This keeps gain changes free of audible steps. When the fade-disable input is high, the target is copied into the applied code on the next frame strobe.

The gain is split into two parts. A whole number of 6 dB groups becomes an arithmetic shift. The remaining 0 to 11 half-decibel steps select one of twelve fixed-point coefficients, which multiply the sample. The scaled sample is registered and presented with a one-cycle valid pulse.

Top module: `vol_ctrl_stereo`

## Requirements
- R1: A channel whose applied code is 0x00 outputs exactly 0, whatever its input sample.
- R2: For an applied code c in 1..255, the output is floor(x * C[r] * 2^(q + BOOST_SHIFT - 14)), where n = c - 207, q = floor(n/12), r = n - 12q and C[r] = round(2^(r/12) * 16384). So 0xCF gives 0 dB, 0xFF gives +24 dB, and each code step is 0.5 dB. BOOST_SHIFT defaults to 1 (+6 dB).
- R3: With fade enabled, the applied code moves one step toward the target on every eighth frame strobe during which it differs from the target, and never overshoots the target.
- R4: With fade_off high, a frame strobe copies the target into the applied code. The sample taken on that strobe uses the old code, and the samples on the following strobes use the new one.
- R5: The left and right channels ramp independently, each toward its own code.
- R6: A change of a channel's target code restarts that channel's eight-frame count from zero.
- R7: Results outside the 24-bit signed range are clamped to 0x7FFFFF or 0x800000 and never wrap.
- R8: After reset, both outputs are 0, out_valid is low and both applied codes are 0x00. With fade enabled, the applied codes then ramp up from there.
- R9: out_valid is high exactly in the cycle after a frame strobe, and the outputs then carry that strobe's samples. Between strobes the outputs hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe per word-clock frame; the input samples are valid with it |
| fade_off | input | 1 | High: skip the ramp and apply the target on the next strobe |
| vol_left | input | 8 | Left volume code (0x00 mute, 0xCF 0 dB, 0xFF +24 dB) |
| vol_right | input | 8 | Right volume code |
| in_left | input | 24 | Left sample, signed two's complement |
| in_right | input | 24 | Right sample, signed two's complement |
| out_left | output | 24 | Scaled and clamped left sample |
| out_right | output | 24 | Scaled and clamped right sample |
| out_valid | output | 1 | High one cycle after each frame strobe |

## Verification
The bench follows the applied code through the outputs, using a fixed input sample, and checks the frame on which each step lands. A step taken one frame early or late shows up as the wrong gain on the eighth or ninth strobe. The bench changes the target part way through a ramp: a design that kept its old count would step after three frames rather than eight. It also checks that a fade-disabled change applies only from the frame after its strobe, that the two channels ramp apart from each other, that the first ramp after reset starts from mute, and that full-scale samples at maximum gain clamp rather than wrap. Coefficients and shifts are derived in the bench from the formula in R2, so an error in the coefficient table or a shift that is off by one group would show a gain wrong by a fraction of a decibel or by 6 dB.

// File: rtl/vol_pkg.sv
package vol_pkg;
    // Half-decibel steps per 6 dB group (one binary shift).
    localparam int STEPS_PER_OCT = 12;
    // Fraction bits of the residual-gain coefficients.
    localparam int COEF_FRAC     = 14;
    localparam int COEF_W        = 16;
    // Code that maps to unity gain.
    localparam int ZERO_DB_CODE  = 207;
    // Whole groups added so that the code offset never goes negative.
    localparam int OCT_BIAS      = (ZERO_DB_CODE + STEPS_PER_OCT - 1) / STEPS_PER_OCT;
    localparam int BIAS_STEPS    = OCT_BIAS * STEPS_PER_OCT - ZERO_DB_CODE;

    // round(2^(idx/12) * 2^14)
    function automatic logic [COEF_W-1:0] frac_coef(input int idx);
        case (idx)
            1:       return 16'd17358;
            2:       return 16'd18390;
            3:       return 16'd19484;
            4:       return 16'd20643;
            5:       return 16'd21870;
            6:       return 16'd23170;
            7:       return 16'd24548;
            8:       return 16'd26008;
            9:       return 16'd27554;
            10:      return 16'd29193;
            11:      return 16'd30929;
            default: return 16'd16384;
        endcase
    endfunction
endpackage

// File: rtl/vol_gain_map.sv
module vol_gain_map
    import vol_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int BOOST_SHIFT = 1,
    parameter int SH_W        = 6
) (
    input  logic [CODE_W-1:0] code,
    output logic [COEF_W-1:0] coef,
    output logic [SH_W-1:0]   shamt,
    output logic              mute
);
    localparam int N_W        = CODE_W + 1;
    // Right shift at bias group 0; must stay >= the largest group index.
    localparam int SHIFT_BASE = COEF_FRAC + OCT_BIAS - BOOST_SHIFT;

    logic [N_W-1:0] steps;
    logic [N_W-1:0] oct;
    logic [N_W-1:0] rem;

    always_comb begin
        steps = {1'b0, code} + N_W'(BIAS_STEPS);
        oct   = steps / N_W'(STEPS_PER_OCT);
        rem   = steps % N_W'(STEPS_PER_OCT);
        coef  = frac_coef(int'(rem));
        shamt = SH_W'(SHIFT_BASE - int'(oct));
        mute  = (code == '0);
    end
endmodule

// File: rtl/vol_ramp.sv
module vol_ramp #(
    parameter int CODE_W      = 8,
    parameter int STEP_FRAMES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              fade_off,
    input  logic [CODE_W-1:0] target,
    output logic [CODE_W-1:0] applied
);
    localparam int CNT_W = (STEP_FRAMES > 1) ? $clog2(STEP_FRAMES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_FRAMES - 1);

    typedef struct packed {
        logic [CODE_W-1:0] cur;
        logic [CODE_W-1:0] tgt;
        logic [CNT_W-1:0]  cnt;
    } ramp_st_t;

    ramp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (target != st_q.tgt) begin
            st_d.tgt = target;
            st_d.cnt = '0;
        end else if (frame_tick) begin
            if (fade_off) begin
                st_d.cur = st_q.tgt;
                st_d.cnt = '0;
            end else if (st_q.cur == st_q.tgt) begin
                st_d.cnt = '0;
            end else if (st_q.cnt == CNT_LAST) begin
                st_d.cnt = '0;
                st_d.cur = (st_q.cur > st_q.tgt) ? st_q.cur - 1'b1 : st_q.cur + 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign applied = st_q.cur;

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cur != $past(st_q.cur) && !$past(fade_off))
        |-> (st_q.cur == $past(st_q.cur) + 1'b1 || st_q.cur == $past(st_q.cur) - 1'b1)); // R3
    AST_TOWARD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cur != $past(st_q.cur) && !$past(fade_off))
        |-> (($past(st_q.cur) < $past(st_q.tgt)) == (st_q.cur > $past(st_q.cur)))); // R3
    AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cur != $past(st_q.cur)) |-> $past(frame_tick)); // R4
    AST_RETARGET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tgt != $past(st_q.tgt)) |-> (st_q.cnt == '0)); // R6
endmodule

// File: rtl/vol_scale.sv
module vol_scale
    import vol_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int SH_W   = 6
) (
    input  logic signed [DATA_W-1:0] sample,
    input  logic [COEF_W-1:0]        coef,
    input  logic [SH_W-1:0]          shamt,
    input  logic                     mute,
    output logic signed [DATA_W-1:0] result
);
    localparam int PROD_W = DATA_W + COEF_W + 1;
    localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((64'sd1 <<< (DATA_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] SAT_LO = -PROD_W'(64'sd1 <<< (DATA_W - 1));

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;
    logic signed [PROD_W-1:0] clamped;

    always_comb begin
        prod    = PROD_W'(sample) * PROD_W'($signed({1'b0, coef}));
        shifted = prod >>> shamt;
        if (mute)                 clamped = '0;
        else if (shifted > SAT_HI) clamped = SAT_HI;
        else if (shifted < SAT_LO) clamped = SAT_LO;
        else                      clamped = shifted;
        result = DATA_W'(clamped);
    end
endmodule

// File: rtl/vol_ctrl_stereo.sv
module vol_ctrl_stereo
    import vol_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int CODE_W      = 8,
    parameter int STEP_FRAMES = 8,
    parameter int BOOST_SHIFT = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_tick,
    input  logic                     fade_off,
    input  logic [CODE_W-1:0]        vol_left,
    input  logic [CODE_W-1:0]        vol_right,
    input  logic signed [DATA_W-1:0] in_left,
    input  logic signed [DATA_W-1:0] in_right,
    output logic signed [DATA_W-1:0] out_left,
    output logic signed [DATA_W-1:0] out_right,
    output logic                     out_valid
);
    localparam int NCH  = 2;
    localparam int SH_W = $clog2(COEF_FRAC + OCT_BIAS + 1);

    typedef struct packed {
        logic                     valid;
        logic signed [DATA_W-1:0] l;
        logic signed [DATA_W-1:0] r;
    } out_st_t;

    logic [CODE_W-1:0]        tgt_code [NCH];
    logic [CODE_W-1:0]        applied  [NCH];
    logic signed [DATA_W-1:0] smp      [NCH];
    logic signed [DATA_W-1:0] scaled   [NCH];

    assign tgt_code[0] = vol_left;
    assign tgt_code[1] = vol_right;
    assign smp[0]      = in_left;
    assign smp[1]      = in_right;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [COEF_W-1:0] coef;
        logic [SH_W-1:0]   shamt;
        logic              mute;

        vol_ramp #(.CODE_W(CODE_W), .STEP_FRAMES(STEP_FRAMES)) u_ramp (
            .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .fade_off(fade_off),
            .target(tgt_code[ch]), .applied(applied[ch]));

        vol_gain_map #(.CODE_W(CODE_W), .BOOST_SHIFT(BOOST_SHIFT), .SH_W(SH_W)) u_map (
            .code(applied[ch]), .coef(coef), .shamt(shamt), .mute(mute));

        vol_scale #(.DATA_W(DATA_W), .SH_W(SH_W)) u_scale (
            .sample(smp[ch]), .coef(coef), .shamt(shamt), .mute(mute),
            .result(scaled[ch]));
    end

    out_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = frame_tick;
        if (frame_tick) begin
            st_d.l = scaled[0];
            st_d.r = scaled[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_left  = st_q.l;
    assign out_right = st_q.r;
    assign out_valid = st_q.valid;

    AST_MUTE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && applied[0] == '0) |=> (out_left == '0)); // R1
    AST_MUTE_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && applied[1] == '0) |=> (out_right == '0)); // R1
    AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> out_valid); // R9
    AST_VALID_ONLY_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> !out_valid); // R9
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_left) && $stable(out_right))); // R9
endmodule

// File: tb/tb_vol_ctrl_stereo.sv
module tb_vol_ctrl_stereo;
    localparam int CLK_PERIOD = 10;
    localparam int BOOST      = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_tick = 1'b0;
    logic fade_off = 1'b0;
    logic [7:0] vol_left = 8'hCF;
    logic [7:0] vol_right = 8'hCF;
    logic signed [23:0] in_left = '0;
    logic signed [23:0] in_right = '0;
    logic signed [23:0] out_left, out_right;
    logic out_valid;

    int total = 0;
    int fails = 0;
    logic signed [23:0] got_l, got_r;
    logic got_v;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vol_ctrl_stereo #(.BOOST_SHIFT(BOOST)) dut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .fade_off(fade_off),
        .vol_left(vol_left), .vol_right(vol_right), .in_left(in_left), .in_right(in_right),
        .out_left(out_left), .out_right(out_right), .out_valid(out_valid));

    function automatic longint expv(longint x, int code);
        int n, q, r, sh;
        longint cf, p;
        if (code == 0) return 0;
        n  = code - 207;
        q  = (n >= 0) ? n / 12 : -((-n + 11) / 12);
        r  = n - 12 * q;
        cf = longint'($rtoi(2.0 ** (r / 12.0) * 16384.0 + 0.5));
        sh = 14 - q - BOOST;
        p  = (x * cf) >>> sh;
        if (p > 64'sd8388607)  p = 64'sd8388607;
        if (p < -64'sd8388608) p = -64'sd8388608;
        return p;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic signed [23:0] xl, input logic signed [23:0] xr);
        @(negedge clk);
        in_left = xl; in_right = xr; frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        got_l = out_left; got_r = out_right; got_v = out_valid;
        repeat (2) @(negedge clk);
    endtask

    task automatic snap(input logic [7:0] cl, input logic [7:0] cr);
        fade_off = 1'b1; vol_left = cl; vol_right = cr;
        tick('0, '0);
        tick('0, '0);
        fade_off = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset out_left", out_left, 0);
        check("R8 reset out_valid", out_valid, 0);
        for (int i = 1; i <= 8; i++) tick(24'sh400000, 24'sh400000);
        check("R8 mute after reset, frame 8", got_l, 0);
        tick(24'sh400000, 24'sh400000);
        check("R8 ramp from mute, frame 9 left", got_l, expv(24'sh400000, 1));
        check("R8 ramp from mute, frame 9 right", got_r, expv(24'sh400000, 1));
    endtask

    task automatic t_mapping;
        int codes [6] = '{207, 255, 200, 100, 1, 215};
        foreach (codes[i]) begin
            snap(8'(codes[i]), 8'(codes[i]));
            tick(24'sd1000, -24'sd77777);
            check("R2 map left", got_l, expv(1000, codes[i]));
            check("R2 map right", got_r, expv(-77777, codes[i]));
        end
    endtask

    task automatic t_mute;
        snap(8'h00, 8'hCF);
        tick(24'sh7FFFFF, 24'sd500);
        check("R1 mute left", got_l, 0);
        check("R1 unmuted right", got_r, expv(500, 207));
    endtask

    task automatic t_saturate;
        snap(8'hFF, 8'hFF);
        tick(24'sh7FFFFF, -24'sh800000);
        check("R7 clamp high", got_l, 8388607);
        check("R7 clamp low", got_r, -8388608);
        snap(8'hCF, 8'hCF);
        tick(24'sh500000, -24'sh500000);
        check("R7 boost overflow high", got_l, 8388607);
        check("R7 boost overflow low", got_r, -8388608);
    endtask

    task automatic t_fade_off;
        snap(8'hCF, 8'hCF);
        fade_off = 1'b1; vol_left = 8'hE0;
        tick(24'sd4096, 24'sd4096);
        check("R4 strobe sample uses old code", got_l, expv(4096, 207));
        tick(24'sd4096, 24'sd4096);
        check("R4 next frame uses new code", got_l, expv(4096, 224));
        fade_off = 1'b0;
    endtask

    task automatic t_ramp;
        snap(8'hCF, 8'hCF);
        vol_left = 8'hD3;
        for (int i = 1; i <= 8; i++) tick(24'sd4096, 24'sd4096);
        check("R3 no step before frame 8", got_l, expv(4096, 207));
        tick(24'sd4096, 24'sd4096);
        check("R3 first step after 8 frames", got_l, expv(4096, 208));
        for (int i = 10; i <= 33; i++) tick(24'sd4096, 24'sd4096);
        check("R3 reaches target", got_l, expv(4096, 211));
        for (int i = 1; i <= 9; i++) tick(24'sd4096, 24'sd4096);
        check("R3 no overshoot", got_l, expv(4096, 211));
    endtask

    task automatic t_retarget;
        snap(8'hCF, 8'hCF);
        vol_left = 8'hD7;
        for (int i = 1; i <= 5; i++) tick(24'sd8192, 24'sd0);
        vol_left = 8'hCB;
        for (int i = 1; i <= 8; i++) tick(24'sd8192, 24'sd0);
        check("R6 count restarted", got_l, expv(8192, 207));
        tick(24'sd8192, 24'sd0);
        check("R6 step down after 8 frames", got_l, expv(8192, 206));
    endtask

    task automatic t_independent;
        snap(8'hCF, 8'hCF);
        vol_left = 8'hD1;
        for (int i = 1; i <= 9; i++) tick(24'sd3000, -24'sd3000);
        check("R5 left ramps", got_l, expv(3000, 208));
        check("R5 right unchanged", got_r, expv(-3000, 207));
    endtask

    task automatic t_hold;
        tick(24'sd1234, 24'sd4321);
        check("R9 valid after strobe", got_v, 1);
        in_left = 24'sd999; in_right = -24'sd999;
        repeat (3) @(negedge clk);
        check("R9 hold left", out_left, got_l);
        check("R9 hold right", out_right, got_r);
        check("R9 valid low between strobes", out_valid, 0);
    endtask

    initial begin
        t_reset();
        t_mapping();
        t_mute();
        t_saturate();
        t_fade_off();
        t_ramp();
        t_retarget();
        t_independent();
        t_hold();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule